// File: doc/BRIEF.md
# Transmit Character Queue with Status Flags

This block sits between a host that produces transmit characters and the encoder that consumes them. It buffers up to `DEPTH` characters (256 by default) of `WIDTH` bits in first-in, first-out order. It presents two status flags to the host. A half-level flag warns that the queue is at least half occupied. A drained flag tells the host that the encoder has nothing left to take. Both sides run on one clock.

The host can flush the queue with a request line. The request must be held for `HOLD_CYC` consecutive clock edges (seven by default) before anything happens, so glitches and short pulses cannot discard data. The flush then runs for `FLUSH_CYC` cycles. During the flush the queue reports itself as unavailable.

A mode input can switch the queue out of the path. In that mode host data passes straight to the encoder, and the flags show a permanently ready transmitter. During a built-in self-test, the drained flag is reused as a marker that pulses at the end of every test sequence. The active level of the drained flag is selectable. The flags also carry output-enable signals that stand in for tri-state pads.

Top module: `tx_char_fifo`

## Requirements
- R1: Characters accepted into the queue are presented on `rd_data` oldest first. The head character is visible whenever the queue is in use and holds at least one entry.
- R2: With the queue in use, no flush running and self-test off, `half_flag` is 1 exactly when the stored count is at least DEPTH/2.
- R3: The drained indication is true when the count is zero. `empty_flag` equals that indication when `pol_sel` = 1, and its inverse when `pol_sel` = 0.
- R4: A write while DEPTH entries are stored and a read while none are stored are both ignored. The count never exceeds DEPTH and never wraps below zero.
- R5: A flush starts only on the edge where `flush_req` has been sampled 1 for HOLD_CYC consecutive edges. A shorter hold leaves the contents untouched. Holding the request beyond that does not start a second flush.
- R6: For the FLUSH_CYC cycles that follow the qualifying edge, `half_flag` reads 1, the drained indication is false, and writes and reads are ignored. After that the queue is empty.
- R7: With `fifo_on` = 0 (bypass), `half_flag` is 0 and the drained indication is true. `rd_data` follows `wr_data`. Writes and reads leave the stored contents unchanged.
- R8: The queue accepts writes and reads only while `fifo_on` = 1 and `ce_n` = 0. `empty_oe` is registered from `ce_n`: on the edge after `ce_n` is sampled 1 it goes to 0, and on the edge after `ce_n` is sampled 0 it goes to 1.
- R9: `half_oe` is 0 exactly while `rst_n` is 0.
- R10: While `bist_n` = 0, the drained indication ignores `fifo_on` and the queue state. It is true only in the SEQ_LEN-th, 2·SEQ_LEN-th, … cycle counted from the cycle in which `bist_n` went low, with the first low cycle counted as cycle 1. Raising `bist_n` restarts that count.
- R11: While `rst_n` = 0 and after its release, the queue is empty: the drained indication is true, `half_flag` = 0 and `empty_oe` = 0 until the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous full reset, active low |
| fifo_on | input | 1 | 1 = queue in path, 0 = bypass |
| ce_n | input | 1 | Chip enable, active low |
| flush_req | input | 1 | Queue flush request, must be held |
| bist_n | input | 1 | Self-test mode, active low |
| pol_sel | input | 1 | Drained flag polarity, 1 = active high |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | WIDTH | Host character |
| rd_en | input | 1 | Encoder read strobe |
| rd_data | output | WIDTH | Character offered to the encoder |
| half_flag | output | 1 | Half-level flag, active high |
| half_oe | output | 1 | Output enable for half_flag |
| empty_flag | output | 1 | Drained flag or self-test marker |
| empty_oe | output | 1 | Output enable for empty_flag |

## Verification
The bench builds the block with DEPTH = 16, SEQ_LEN = 5, HOLD_CYC = 7 and FLUSH_CYC = 4. With the small depth, every fill level from zero past full, and back down again, can be stepped through and checked against the arithmetic half mark. Overflow and underflow are reached in a few dozen cycles. The short test sequence lets three complete marker periods be checked under both polarities and both path modes, and the flush timing is followed edge by edge through hold, flush and release.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
   typedef struct packed {
      logic half;
      logic drained;
   } tcf_flags_t;
endpackage

// File: rtl/tcf_flush_seq.sv
module tcf_flush_seq #(
   parameter int unsigned HOLD_CYC  = 7,
   parameter int unsigned FLUSH_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_req,
   output logic busy
);
   localparam int unsigned HW = $clog2(HOLD_CYC + 1);
   localparam int unsigned FW = $clog2(FLUSH_CYC + 1);
   localparam logic [HW-1:0] HOLD_TOP = HW'(HOLD_CYC);
   localparam logic [FW-1:0] RUN_LEN  = FW'(FLUSH_CYC);

   logic [HW-1:0] hold_q;
   logic [FW-1:0] left_q;
   logic          qualify;

   // the edge that completes the hold window
   assign qualify = flush_req && (hold_q == HOLD_TOP - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         left_q <= '0;
      end else begin
         if (!flush_req)
            hold_q <= '0;
         else if (hold_q != HOLD_TOP)
            hold_q <= hold_q + 1'b1;
         if (qualify)
            left_q <= RUN_LEN;
         else if (left_q != '0)
            left_q <= left_q - 1'b1;
      end
   end

   assign busy = (left_q != '0);
endmodule

// File: rtl/tcf_store.sv
module tcf_store #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned WIDTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         push,
   input  logic                         pop,
   input  logic [WIDTH-1:0]             wdata,
   output logic [WIDTH-1:0]             rdata,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    lvl_q;
   logic             do_push, do_pop;

   assign do_push = push && (lvl_q != FULL_LVL);
   assign do_pop  = pop && (lvl_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else if (clear) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clear) mem[wp_q] <= wdata;
   end

   assign rdata = mem[rp_q];
   assign level = lvl_q;
endmodule

// File: rtl/tcf_bist_tick.sv
module tcf_bist_tick #(
   parameter int unsigned SEQ_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int unsigned BW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
   localparam logic [BW-1:0] LAST_IDX = BW'(SEQ_LEN - 1);

   logic [BW-1:0] cnt_q;

   generate
      if (SEQ_LEN == (1 << BW)) begin : g_pow2
         // natural wrap of the counter marks the sequence end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (!run) cnt_q <= '0;
            else          cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (!run)             cnt_q <= '0;
            else if (cnt_q == LAST_IDX) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   assign last = run && (cnt_q == LAST_IDX);
endmodule

// File: rtl/tcf_flag_mux.sv
module tcf_flag_mux
   import tcf_pkg::*;
#(
   parameter int unsigned DEPTH = 256
) (
   input  logic                       fifo_on,
   input  logic                       busy,
   input  logic                       bist_on,
   input  logic                       bist_last,
   input  logic                       pol_sel,
   input  logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       half_flag,
   output logic                       empty_flag
);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);

   tcf_flags_t flg;

   always_comb begin
      if (!fifo_on) begin
         flg.half    = 1'b0;
         flg.drained = 1'b1;
      end else if (busy) begin
         flg.half    = 1'b1;
         flg.drained = 1'b0;
      end else begin
         flg.half    = (level >= HALF_MARK);
         flg.drained = (level == '0);
      end
      if (bist_on) flg.drained = bist_last;
   end

   assign half_flag  = flg.half;
   assign empty_flag = pol_sel ? flg.drained : !flg.drained;
endmodule

// File: rtl/tx_char_fifo.sv
module tx_char_fifo #(
   parameter int unsigned DEPTH     = 256,
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned HOLD_CYC  = 7,
   parameter int unsigned FLUSH_CYC = 4,
   parameter int unsigned SEQ_LEN   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_on,
   input  logic             ce_n,
   input  logic             flush_req,
   input  logic             bist_n,
   input  logic             pol_sel,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             half_flag,
   output logic             half_oe,
   output logic             empty_flag,
   output logic             empty_oe
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 4");
      assert (WIDTH >= 1) else $error("WIDTH must be positive");
      assert (HOLD_CYC >= 1) else $error("HOLD_CYC must be at least 1");
      assert (FLUSH_CYC >= 1) else $error("FLUSH_CYC must be at least 1");
      assert (SEQ_LEN >= 2) else $error("SEQ_LEN must be at least 2");
   end

   logic             flush_busy;
   logic             gate;
   logic [WIDTH-1:0] q_head;
   logic [CW-1:0]    level;
   logic             bist_last;
   logic             oe_q;

   tcf_flush_seq #(.HOLD_CYC(HOLD_CYC), .FLUSH_CYC(FLUSH_CYC)) i_flush (
      .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .busy(flush_busy)
   );

   assign gate = fifo_on && !ce_n && !flush_busy;

   tcf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
      .clk(clk), .rst_n(rst_n), .clear(flush_busy),
      .push(wr_en && gate), .pop(rd_en && gate),
      .wdata(wr_data), .rdata(q_head), .level(level)
   );

   tcf_bist_tick #(.SEQ_LEN(SEQ_LEN)) i_bist (
      .clk(clk), .rst_n(rst_n), .run(!bist_n), .last(bist_last)
   );

   tcf_flag_mux #(.DEPTH(DEPTH)) i_flags (
      .fifo_on(fifo_on), .busy(flush_busy), .bist_on(!bist_n),
      .bist_last(bist_last), .pol_sel(pol_sel), .level(level),
      .half_flag(half_flag), .empty_flag(empty_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= !ce_n;
   end

   assign empty_oe = oe_q;
   assign half_oe  = rst_n;
   assign rd_data  = fifo_on ? q_head : wr_data;
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
   parameter int unsigned DEPTH = 256
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       fifo_on,
   input logic                       ce_n,
   input logic                       bist_n,
   input logic                       pol_sel,
   input logic                       half_flag,
   input logic                       empty_flag,
   input logic                       empty_oe,
   input logic                       busy,
   input logic [$clog2(DEPTH+1)-1:0] level
);
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= int'(DEPTH));

   assert_level_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> (int'(level) == int'($past(level)) ||
                        int'(level) == int'($past(level)) + 1 ||
                        int'(level) + 1 == int'($past(level))));

   assert_half_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && !busy) |-> (half_flag == (int'(level) >= int'(DEPTH / 2))));

   assert_bypass_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_on |-> !half_flag);

   assert_flush_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fifo_on && bist_n) |-> (half_flag && empty_flag != pol_sel));

   assert_flush_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (level == '0));

   assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !empty_oe);

   assert_bist_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bist_n && !$past(bist_n) && $stable(pol_sel) && $past(empty_flag == pol_sel))
         |-> (empty_flag != pol_sel));
endmodule

bind tx_char_fifo tcf_checker #(.DEPTH(DEPTH)) i_tcf_chk (
   .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .ce_n(ce_n),
   .bist_n(bist_n), .pol_sel(pol_sel), .half_flag(half_flag),
   .empty_flag(empty_flag), .empty_oe(empty_oe),
   .busy(flush_busy), .level(level)
);

// File: tb/test_tx_char_fifo.sv
module test_tx_char_fifo;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned WIDTH = 8;
   localparam int unsigned HOLD  = 7;
   localparam int unsigned FLUSH = 4;
   localparam int unsigned SEQ   = 5;
   localparam int unsigned HALF  = DEPTH / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_on = 1'b1, ce_n = 1'b0, flush_req = 1'b0, bist_n = 1'b1, pol_sel = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic [WIDTH-1:0] rd_data;
   logic half_flag, half_oe, empty_flag, empty_oe;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   int wseq = 0;
   logic [7:0] model[$];

   always #2 clk = ~clk;

   tx_char_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .HOLD_CYC(HOLD),
                  .FLUSH_CYC(FLUSH), .SEQ_LEN(SEQ)) i_tx_char_fifo (
      .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .ce_n(ce_n),
      .flush_req(flush_req), .bist_n(bist_n), .pol_sel(pol_sel),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .half_flag(half_flag), .half_oe(half_oe),
      .empty_flag(empty_flag), .empty_oe(empty_oe)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   // drained indication mapped through the polarity select
   function automatic int dr(int logical);
      return pol_sel ? logical : (logical == 0 ? 1 : 0);
   endfunction

   task automatic push_one();
      wr_data = pat(wseq);
      wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
      if (model.size() < DEPTH && fifo_on && !ce_n) model.push_back(pat(wseq));
      wseq++;
   endtask

   task automatic pop_one(string req);
      check(req, int'(rd_data), int'(model[0]));
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      void'(model.pop_front());
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         report();
      end
   end

   initial begin
      // reset state: R9, R11
      repeat (3) tick();
      check("R9 half_oe in reset", int'(half_oe), 0);
      check("R11 empty_oe in reset", int'(empty_oe), 0);
      rst_n = 1'b1;
      #1;
      check("R9 half_oe after reset", int'(half_oe), 1);
      check("R11 drained after reset", int'(empty_flag), 1);
      check("R11 half after reset", int'(half_flag), 0);
      tick();
      check("R8 empty_oe enabled", int'(empty_oe), 1);

      // fill sweep past full: R2, R3, R4
      for (int i = 0; i < DEPTH + 2; i++) begin
         push_one();
         check("R2 half during fill", int'(half_flag), (model.size() >= HALF) ? 1 : 0);
         check("R3 drained during fill", int'(empty_flag), 0);
      end
      check("R4 level capped at full", model.size(), DEPTH);

      // drain sweep: R1, R2, R3
      for (int i = 0; i < DEPTH; i++) begin
         pop_one("R1 order on drain");
         check("R2 half during drain", int'(half_flag), (model.size() >= HALF) ? 1 : 0);
         check("R3 drained during drain", int'(empty_flag), (model.size() == 0) ? 1 : 0);
      end
      // read while empty is ignored: R4
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      check("R4 empty read ignored", int'(empty_flag), 1);
      push_one();
      check("R4 no underflow wrap, drained", int'(empty_flag), 0);
      check("R4 no underflow wrap, head", int'(rd_data), int'(pat(wseq - 1)));
      pop_one("R4 single entry order");

      // polarity: R3
      pol_sel = 1'b0;
      #1;
      check("R3 active-low drained", int'(empty_flag), 0);
      push_one();
      check("R3 active-low not drained", int'(empty_flag), 1);
      pol_sel = 1'b1;
      #1;
      pop_one("R1 order after polarity");

      // short flush hold: R5
      repeat (3) push_one();
      flush_req = 1'b1;
      repeat (HOLD - 1) tick();
      flush_req = 1'b0;
      tick();
      check("R5 short hold keeps data", int'(empty_flag), 0);
      check("R5 short hold keeps head", int'(rd_data), int'(model[0]));
      repeat (4) tick();
      check("R5 no late flush", int'(empty_flag), 0);

      // qualified flush traced edge by edge: R5, R6
      flush_req = 1'b1;
      for (int k = 1; k <= 14; k++) begin
         tick();
         wr_en = 1'b0;
         if (k < HOLD) begin
            check("R5 before qualify half", int'(half_flag), 0);
            check("R5 before qualify drained", int'(empty_flag), 0);
         end else if (k < HOLD + FLUSH) begin
            check("R6 flush half forced", int'(half_flag), 1);
            check("R6 flush drained off", int'(empty_flag), 0);
         end else begin
            check("R6 after flush drained", int'(empty_flag), 1);
            check("R6 after flush half", int'(half_flag), 0);
         end
         if (k == HOLD + FLUSH - 1) begin
            wr_data = 8'hC3;
            wr_en = 1'b1;
         end
      end
      flush_req = 1'b0;
      model.delete();

      // bypass: R7
      repeat (3) push_one();
      fifo_on = 1'b0;
      wr_data = 8'h5A;
      #1;
      check("R7 bypass half", int'(half_flag), 0);
      check("R7 bypass drained", int'(empty_flag), 1);
      check("R7 bypass passthrough", int'(rd_data), 8'h5A);
      wr_en = 1'b1;
      rd_en = 1'b1;
      tick();
      wr_en = 1'b0;
      rd_en = 1'b0;
      check("R7 bypass drained after access", int'(empty_flag), 1);
      pol_sel = 1'b0;
      #1;
      check("R7 bypass drained active low", int'(empty_flag), 0);
      pol_sel = 1'b1;
      fifo_on = 1'b1;
      #1;
      check("R7 contents kept across bypass", int'(rd_data), int'(model[0]));
      check("R7 not drained after bypass", int'(empty_flag), 0);

      // chip enable: R8
      repeat (4) push_one();
      check("R2 one below mark", int'(half_flag), 0);
      ce_n = 1'b1;
      push_one();
      check("R8 empty_oe released", int'(empty_oe), 0);
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      ce_n = 1'b0;
      tick();
      check("R8 empty_oe restored", int'(empty_oe), 1);
      check("R8 write ignored", int'(half_flag), 0);
      check("R8 read ignored", int'(rd_data), int'(model[0]));
      push_one();
      check("R2 at mark", int'(half_flag), 1);
      while (model.size() > 0) pop_one("R1 order after enable");
      check("R3 drained at end", int'(empty_flag), 1);

      // self-test marker, queue in path: R10
      bist_n = 1'b0;
      #1;
      for (int c = 1; c <= 3 * SEQ; c++) begin
         check("R10 marker in path", int'(empty_flag), dr((c % SEQ) == 0 ? 1 : 0));
         tick();
      end
      bist_n = 1'b1;
      tick();
      check("R10 normal after test", int'(empty_flag), 1);

      // self-test marker, bypass and active low, restarted count: R10
      fifo_on = 1'b0;
      pol_sel = 1'b0;
      tick();
      bist_n = 1'b0;
      #1;
      for (int c = 1; c <= 3 * SEQ; c++) begin
         check("R10 marker in bypass", int'(empty_flag), dr((c % SEQ) == 0 ? 1 : 0));
         tick();
      end
      bist_n = 1'b1;
      fifo_on = 1'b1;
      pol_sel = 1'b1;
      tick();

      // reset during operation: R9, R11
      repeat (2) push_one();
      rst_n = 1'b0;
      #1;
      check("R9 half_oe in late reset", int'(half_oe), 0);
      check("R11 drained in late reset", int'(empty_flag), 1);
      tick();
      rst_n = 1'b1;
      #1;
      check("R11 half after late reset", int'(half_flag), 0);
      model.delete();

      done = 1;
      report();
   end
endmodule